// File: doc/BRIEF.md
# Shared-Bus Multi-Cycle 16-bit Core

This block is a small 16-bit processor core. All internal data movement runs over one internal bus. Three sources can drive that bus through gated drivers: the program counter, the ALU result and the memory data register. Each destination register captures the bus value when its load enable is high. Only one value can travel per clock, so a control state machine splits every instruction into micro-steps of one clock each. In each step one gate drives the bus and one register listens. The exceptions are the memory-read step and the PC-increment step, which do not use the bus.

The core executes two instructions: a register-to-register add and a load from memory at base register plus signed offset. All memory traffic goes through a memory address register and a memory data register. These face an external word memory that answers a read request with a valid strobe, and that memory may insert any number of wait states. Because of this, an instruction's length depends on its kind and on the memory latency. A free-running cycle counter lets a user measure those lengths.

Top module: `sbus_core`

## Requirements
- R1: While `rst_ni` is low, PC, IR, MAR, MDR, all eight registers and the cycle counter are zero. The first clock after reset starts a fetch, and the first read request is made to address 0.
- R2: At most one bus source is gated in any cycle. When none is gated, `bus_o` reads zero.
- R3: Fetch has four steps. First PC goes over the bus into MAR. Then memory is read into MDR. Then MDR goes over the bus into IR. Then PC increments by 1. With zero wait states a fetch costs exactly 4 clocks, and PC only ever holds or steps by 1.
- R4: Opcode bits [15:12] = 0001 is ADD, with destination in [11:9], first source in [8:6] and second source in [2:0]. Its execute phase is one clock, and it writes (src1 + src2) mod 2^16 to the destination.
- R5: Opcode 0110 is LDR, with destination in [11:9], base in [8:6] and a signed 6-bit offset in [5:0]. It reads the word at base + sign-extended offset into the destination. Its execute phase is 3 clocks plus the read wait states.
- R6: A read holds in its wait state, with the request high and the address stable, until `mem_valid_i` is high. Each wait cycle adds exactly one clock. MDR loads only in a cycle where the memory reports valid.
- R7: Any other opcode is a no-op. It writes no register and goes straight to the next fetch, so its total length is the fetch length.
- R8: `cycle_cnt_o` increases by exactly 1 on every clock after reset.
- R9: A register write is visible at the ports as `rf_we_o` high for one clock. During that clock `rf_waddr_o` holds the destination and `bus_o` holds the written value. R0 is an ordinary writable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_req_o | output | 1 | Read request, high in both read states |
| mem_addr_o | output | 16 | Read address (MAR contents) |
| mem_rdata_i | input | 16 | Read data from memory |
| mem_valid_i | input | 1 | Read data valid this cycle |
| bus_o | output | 16 | Current value of the shared bus |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_waddr_o | output | 3 | Register-file write index |
| pc_o | output | 16 | Program counter |
| cycle_cnt_o | output | 32 | Clocks since reset |

## Verification
The assertions take for granted that the memory raises `mem_valid_i` only while `mem_req_o` is high, and that it returns the word at the address shown in that same cycle. They also assume the memory eventually answers, so no read waits forever. The bench memory model meets these conditions by construction: it counts the cycles a request has been pending and raises valid only when that count reaches the latency chosen for the run. The stimulus sweeps that latency from zero to three wait states. In every run, the program's load addresses stay inside the modelled memory.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_LDR = 4'b0110;

  typedef enum logic [3:0] {
    ST_FET_ADR, ST_FET_RD, ST_FET_IR, ST_FET_INC,
    ST_ADD_EX,  ST_LDR_ADR, ST_LDR_RD, ST_LDR_WB
  } state_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_NOT} alu_op_e;

  typedef struct packed {
    logic    gate_pc;
    logic    gate_alu;
    logic    gate_mdr;
    logic    ld_mar;
    logic    ld_mdr;
    logic    ld_ir;
    logic    ld_pc;
    logic    ld_reg;
    logic    b_imm;
    alu_op_e alu_op;
    logic    mem_req;
  } ctrl_t;

endpackage

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_op_e       op_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_NOT: y_o = ~a_i;
      default: y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 8,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  input  logic [AW-1:0] wa_i,
  input  logic          we_i,
  input  logic [DW-1:0] wd_i,
  output logic [DW-1:0] rda_o,
  output logic [DW-1:0] rdb_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        regs_q[g] <= '0;
      else if (we_i && wa_i == AW'(g))    regs_q[g] <= wd_i;
    end
  end

  assign rda_o = regs_q[ra_i];
  assign rdb_o = regs_q[rb_i];
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] opcode_i,
  input  logic       mem_valid_i,
  output ctrl_t      ctl_o
);
  state_e st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_FET_ADR;
    else         st_q <= st_d;
  end

  always_comb begin
    ctl_o  = '0;
    ctl_o.alu_op = ALU_ADD;
    st_d   = st_q;
    unique case (st_q)
      ST_FET_ADR: begin ctl_o.gate_pc = 1'b1; ctl_o.ld_mar = 1'b1; st_d = ST_FET_RD; end
      ST_FET_RD: begin
        ctl_o.mem_req = 1'b1;
        if (mem_valid_i) begin ctl_o.ld_mdr = 1'b1; st_d = ST_FET_IR; end
      end
      ST_FET_IR:  begin ctl_o.gate_mdr = 1'b1; ctl_o.ld_ir = 1'b1; st_d = ST_FET_INC; end
      ST_FET_INC: begin
        ctl_o.ld_pc = 1'b1;
        // IR already holds the new word here
        unique case (opcode_i)
          OPC_ADD: st_d = ST_ADD_EX;
          OPC_LDR: st_d = ST_LDR_ADR;
          default: st_d = ST_FET_ADR;
        endcase
      end
      ST_ADD_EX:  begin ctl_o.gate_alu = 1'b1; ctl_o.ld_reg = 1'b1; st_d = ST_FET_ADR; end
      ST_LDR_ADR: begin
        ctl_o.gate_alu = 1'b1; ctl_o.b_imm = 1'b1; ctl_o.ld_mar = 1'b1; st_d = ST_LDR_RD;
      end
      ST_LDR_RD: begin
        ctl_o.mem_req = 1'b1;
        if (mem_valid_i) begin ctl_o.ld_mdr = 1'b1; st_d = ST_LDR_WB; end
      end
      ST_LDR_WB:  begin ctl_o.gate_mdr = 1'b1; ctl_o.ld_reg = 1'b1; st_d = ST_FET_ADR; end
      default:    st_d = ST_FET_ADR;
    endcase
  end
endmodule

// File: rtl/sbus_core.sv
module sbus_core
  import sbus_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 8,
  parameter int unsigned CW   = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_valid_i,
  output logic [DW-1:0] bus_o,
  output logic          rf_we_o,
  output logic [AW-1:0] rf_waddr_o,
  output logic [DW-1:0] pc_o,
  output logic [CW-1:0] cycle_cnt_o
);
  ctrl_t         ctl;
  logic [DW-1:0] pc_q, ir_q, mar_q, mdr_q, bus;
  logic [DW-1:0] rda, rdb, alu_b, alu_y, sext_off;
  logic [CW-1:0] cnt_q;
  logic          gate_pc, gate_alu, gate_mdr;

  sbus_ctrl u_ctrl (
    .clk_i, .rst_ni, .opcode_i(ir_q[15:12]), .mem_valid_i, .ctl_o(ctl)
  );

  sbus_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni,
    .ra_i(ir_q[8:6]), .rb_i(ir_q[2:0]), .wa_i(ir_q[11:9]),
    .we_i(ctl.ld_reg), .wd_i(bus), .rda_o(rda), .rdb_o(rdb)
  );

  assign sext_off = {{(DW-6){ir_q[5]}}, ir_q[5:0]};
  assign alu_b    = ctl.b_imm ? sext_off : rdb;

  sbus_alu #(.DW(DW)) u_alu (.a_i(rda), .b_i(alu_b), .op_i(ctl.alu_op), .y_o(alu_y));

  assign gate_pc  = ctl.gate_pc;
  assign gate_alu = ctl.gate_alu;
  assign gate_mdr = ctl.gate_mdr;

  // AND-OR bus: undriven reads as zero
  assign bus = ({DW{gate_pc}} & pc_q) | ({DW{gate_alu}} & alu_y) | ({DW{gate_mdr}} & mdr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
      if (ctl.ld_pc)  pc_q  <= pc_q + DW'(1);
      if (ctl.ld_ir)  ir_q  <= bus;
      if (ctl.ld_mar) mar_q <= bus;
      if (ctl.ld_mdr) mdr_q <= mem_rdata_i;
    end
  end

  assign mem_req_o   = ctl.mem_req;
  assign mem_addr_o  = mar_q;
  assign bus_o       = bus;
  assign rf_we_o     = ctl.ld_reg;
  assign rf_waddr_o  = ir_q[11:9];
  assign pc_o        = pc_q;
  assign cycle_cnt_o = cnt_q;
endmodule

// File: rtl/sbus_core_chk.sv
module sbus_core_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          gate_pc,
  input logic          gate_alu,
  input logic          gate_mdr,
  input logic [DW-1:0] bus_o,
  input logic          mem_req_o,
  input logic          mem_valid_i,
  input logic [DW-1:0] mem_addr_o,
  input logic [DW-1:0] pc_o,
  input logic [CW-1:0] cycle_cnt_o
);
  assert_one_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({gate_pc, gate_alu, gate_mdr}) <= 1);

  assert_bus_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_pc || gate_alu || gate_mdr) |-> bus_o == '0);

  assert_pc_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pc_o == $past(pc_o) || pc_o == $past(pc_o) + DW'(1)));

  assert_read_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_fetch_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_pc |=> mem_addr_o == $past(pc_o));

  assert_cnt_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cycle_cnt_o == $past(cycle_cnt_o) + CW'(1));
endmodule

bind sbus_core sbus_core_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .gate_pc(gate_pc), .gate_alu(gate_alu), .gate_mdr(gate_mdr),
  .bus_o(bus_o), .mem_req_o(mem_req_o), .mem_valid_i(mem_valid_i),
  .mem_addr_o(mem_addr_o), .pc_o(pc_o), .cycle_cnt_o(cycle_cnt_o)
);

// File: tb/sim_sbus_core.sv
module sim_sbus_core;
  localparam int NPROG = 22;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_req_o, mem_valid_i, rf_we_o;
  logic [15:0] mem_addr_o, mem_rdata_i, bus_o, pc_o;
  logic [2:0]  rf_waddr_o;
  logic [31:0] cycle_cnt_o;

  logic [15:0] mem [256];
  logic [15:0] prog [NPROG];
  int lat = 0;
  int wcnt = 0;
  int n_chk = 0;
  int n_err = 0;
  bit running = 1'b0;

  logic [2:0]  exp_wa [64];
  logic [15:0] exp_wd [64];
  int exp_len [NPROG];
  int n_exp = 0;
  int wi = 0;
  int last_pc = 0;
  int last_stamp = 0;

  always #4 clk = ~clk;

  sbus_core u0 (
    .clk_i(clk), .rst_ni, .mem_req_o, .mem_addr_o, .mem_rdata_i, .mem_valid_i,
    .bus_o, .rf_we_o, .rf_waddr_o, .pc_o, .cycle_cnt_o
  );

  assign mem_rdata_i = mem[mem_addr_o[7:0]];
  assign mem_valid_i = mem_req_o && (wcnt == lat);

  always @(posedge clk) begin
    if (!rst_ni)                       wcnt <= 0;
    else if (mem_req_o && !mem_valid_i) wcnt <= wcnt + 1;
    else                               wcnt <= 0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h (lat=%0d)", req, act, exp, lat);
    end
  endtask

  function automatic logic [15:0] enc_add(int d, int a, int b);
    return {4'b0001, 3'(d), 3'(a), 3'b000, 3'(b)};
  endfunction

  function automatic logic [15:0] enc_ldr(int d, int b, int off);
    return {4'b0110, 3'(d), 3'(b), 6'(off)};
  endfunction

  function automatic string tag_of(logic [15:0] w);
    if (w[15:12] == 4'b0001) return "R4";
    if (w[15:12] == 4'b0110) return "R5";
    return "R7";
  endfunction

  task automatic build;
    logic [15:0] r [8];
    for (int a = 0; a < 256; a++) mem[a] = 16'(a * 16'h9E37) ^ 16'h5A5A;
    mem[8'h1F] = 16'h0040;
    mem[8'h3D] = 16'hFFFF;
    prog[0] = enc_add(5, 6, 7);
    prog[1] = enc_ldr(1, 0, 31);
    prog[2] = enc_ldr(2, 1, -3);
    prog[3] = enc_ldr(3, 1, 31);
    prog[4] = enc_ldr(4, 1, -32);
    prog[5] = enc_ldr(6, 1, 0);
    prog[6] = enc_ldr(7, 1, 1);
    prog[7] = enc_ldr(0, 1, 2);
    prog[8] = 16'hF000;
    for (int i = 0; i < 9; i++) prog[9+i] = enc_add((i*3+1)%8, (i*5+2)%8, (i*7+3)%8);
    prog[18] = enc_add(5, 2, 2);
    prog[19] = 16'h0000;
    prog[20] = enc_add(0, 0, 0);
    prog[21] = 16'hF000;
    for (int k = 0; k < NPROG; k++) mem[k] = prog[k];
    // reference model from the instruction definitions
    for (int k = 0; k < 8; k++) r[k] = '0;
    n_exp = 0;
    for (int k = 0; k < NPROG; k++) begin
      logic [15:0] w, ad;
      w = prog[k];
      exp_len[k] = 0;
      if (w[15:12] == 4'b0001) begin
        r[w[11:9]] = r[w[8:6]] + r[w[2:0]];
        exp_len[k] = 1;
      end else if (w[15:12] == 4'b0110) begin
        ad = r[w[8:6]] + {{10{w[5]}}, w[5:0]};
        r[w[11:9]] = mem[ad[7:0]];
        exp_len[k] = 3 + lat;
      end else continue;
      exp_wa[n_exp] = w[11:9];
      exp_wd[n_exp] = r[w[11:9]];
      n_exp++;
    end
  endtask

  // monitor: register writes and per-instruction cycle counts
  always @(negedge clk) begin
    if (running && rst_ni) begin
      if (rf_we_o) begin
        if (wi < n_exp) begin
          chk(rf_waddr_o == exp_wa[wi], "R9", 32'(rf_waddr_o), 32'(exp_wa[wi]));
          chk(bus_o == exp_wd[wi], "R9", 32'(bus_o), 32'(exp_wd[wi]));
        end else chk(1'b0, "R7", 32'(wi), 32'(n_exp));
        wi++;
      end
      if (int'(pc_o) != last_pc) begin
        int e;
        string t;
        e = 4 + lat;
        t = "R3";
        if (pc_o >= 2) begin
          e += exp_len[pc_o-2];
          t = tag_of(prog[pc_o-2]);
        end
        chk(int'(cycle_cnt_o) - last_stamp == e, t, cycle_cnt_o - 32'(last_stamp), 32'(e));
        last_stamp = int'(cycle_cnt_o);
        last_pc = int'(pc_o);
      end
    end
  end

  initial begin
    for (int L = 0; L < 4; L++) begin
      running = 1'b0;
      rst_ni = 1'b0;
      lat = L;
      build();
      wi = 0; last_pc = 0; last_stamp = 0;
      repeat (3) @(negedge clk);
      // R1: reset state, before the first active edge
      chk(pc_o == 16'h0, "R1", 32'(pc_o), 0);
      chk(cycle_cnt_o == 0, "R1", cycle_cnt_o, 0);
      chk(mem_addr_o == 16'h0 && !mem_req_o && !rf_we_o, "R1", 32'(mem_addr_o), 0);
      chk(bus_o == 16'h0, "R2", 32'(bus_o), 0);
      rst_ni = 1'b1;
      running = 1'b1;
      @(negedge clk);
      chk(cycle_cnt_o == 1, "R8", cycle_cnt_o, 1);
      // R1/R6: read of address 0 held through the wait states
      for (int j = 0; j <= L; j++) begin
        chk(mem_req_o && mem_addr_o == 16'h0, "R6", {15'h0, mem_req_o, mem_addr_o}, 32'h10000);
        chk(bus_o == 16'h0, "R2", 32'(bus_o), 0);
        @(negedge clk);
      end
      chk(!mem_req_o, "R6", 32'(mem_req_o), 0);
      begin
        int t = 0;
        while (int'(pc_o) != NPROG && t < 5000) begin
          @(negedge clk);
          t++;
        end
        if (t >= 5000) chk(1'b0, "R3", 32'(pc_o), NPROG);
      end
      chk(wi == n_exp, "R7", 32'(wi), 32'(n_exp));
    end
    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R3", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule